// File: doc/BRIEF.md
# MD5 Block Compression Engine

This engine applies the MD5 compression function to a single 512-bit message block that has already been padded. One step of the 64-step schedule runs on each clock. When the work is finished, the engine adds the chaining value it started from back into the result. A one-cycle start strobe launches a block. A busy flag stays high while the steps run. A one-cycle done pulse marks the cycle in which the new chaining value appears.

A multi-block message is hashed by feeding the blocks in sequence. The first block is started with the init input raised, so the engine takes the fixed MD5 initial vector and ignores the state input. Each later block is started with init low and the previous `state_o` on `state_i`.

The result is provided in two forms. The first is the raw word form, used for chaining. The second is the 128-bit digest in conventional byte order, ready for comparison with a target hash.

Top module: `md5_core`

## Requirements
- R1: After a synchronous active-low reset, `busy_o` and `done_o` are 0, and `state_o` and `digest_o` are all zeros.
- R2: A `start_i` sampled high while the engine is idle raises `busy_o` at that clock edge. `busy_o` stays high for exactly 64 cycles. On the 64th edge after the start edge, `busy_o` falls and `done_o` is high for exactly one cycle. A new start may be accepted in that same done cycle.
- R3: With `init_i` high at the start edge, the input chaining value is A=0x67452301, B=0xEFCDAB89, C=0x98BADCFE, D=0x10325476, and `state_i` has no effect on the result.
- R4: With `init_i` low at the start edge, the input chaining value is taken from `state_i` = {A, B, C, D}, with A in bits 127:96 and D in bits 31:0.
- R5: Message word j of the block is `block_i[32*j+31 : 32*j]`, numbered 0 to 15. The 64 steps use the standard round functions, sine-derived constants, rotation amounts and word orders of MD5. As a result, the padded empty message yields digest d41d8cd98f00b204e9800998ecf8427e and the padded message "abc" yields 900150983cd24fb0d6963f7d28e17f72.
- R6: Each output word of `state_o` equals the corresponding input chaining word plus the word produced by the 64 steps, modulo 2^32. This makes a two-block message hash correctly when chained through `state_o`.
- R7: `digest_o` presents the bytes of A, then B, C and D, each word least-significant byte first. Byte 0 (the low byte of A) is in bits 127:120.
- R8: While `busy_o` is high, `start_i`, `init_i`, `block_i` and `state_i` have no effect on the running computation, on its result or on its timing.
- R9: `state_o` and `digest_o` change only at the edge that raises `done_o` and otherwise hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Launch a block when idle |
| init_i | input | 1 | Use the fixed initial vector instead of `state_i` |
| block_i | input | 512 | Padded block, word j at bits 32j+31:32j |
| state_i | input | 128 | Input chaining value {A,B,C,D} |
| busy_o | output | 1 | Steps in progress |
| done_o | output | 1 | One-cycle pulse, result valid |
| state_o | output | 128 | Output chaining value {A,B,C,D} |
| digest_o | output | 128 | Digest in byte order, byte 0 in bits 127:120 |

## Verification
The hardest case to reach is a start request that arrives while a block is running, together with inputs that change under it. It must leave both the timing and the result untouched. The stimulus covers it by pulsing `start_i` in the middle of a run while swapping `block_i`, `state_i` and `init_i`. It also raises a fresh start in exactly the cycle where `done_o` is high, which must be accepted. A behavioural reference that counts cycles tracks every one of these cases, and a second behavioural hash function predicts the result of each accepted block. The second block of a chained message is started with init low on the first block's output, and the init-high case is driven with a deliberately wrong `state_i`.

// File: rtl/md5_pkg.sv
// Package md5_pkg
// Shared constants and pure helper functions for the MD5 compression engine.
// Assumes 32-bit words, 16 words per block and 64 steps (fixed by the hash).
package md5_pkg;

    localparam int WORD_W    = 32;
    localparam int NUM_WORDS = 16;
    localparam int NUM_STEPS = 64;
    localparam int STEP_W    = $clog2(NUM_STEPS);
    localparam int IDX_W     = $clog2(NUM_WORDS);
    localparam int ROT_W     = $clog2(WORD_W);
    localparam int BLOCK_W   = WORD_W * NUM_WORDS;
    localparam int STATE_W   = WORD_W * 4;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [STEP_W-1:0] step_t;

    localparam word_t IV_A = 32'h67452301;
    localparam word_t IV_B = 32'hefcdab89;
    localparam word_t IV_C = 32'h98badcfe;
    localparam word_t IV_D = 32'h10325476;

    // Rotate a word left by s (s is never zero in this hash).
    function automatic word_t rotl32(word_t x, logic [ROT_W-1:0] s);
        return (x << s) | (x >> (6'd32 - {1'b0, s}));
    endfunction

    // Reverse the byte order of a word.
    function automatic word_t bswap32(word_t x);
        return {x[7:0], x[15:8], x[23:16], x[31:24]};
    endfunction

    // Message word index used by a given step.
    function automatic logic [IDX_W-1:0] msg_index(step_t st);
        logic [IDX_W-1:0] i4;
        i4 = st[IDX_W-1:0];
        case (st[STEP_W-1:STEP_W-2])
            2'd0:    return i4;
            2'd1:    return i4 * 4'd5 + 4'd1;
            2'd2:    return i4 * 4'd3 + 4'd5;
            default: return i4 * 4'd7;
        endcase
    endfunction

    // Left-rotation amount of a given step.
    function automatic logic [ROT_W-1:0] rot_amount(step_t st);
        logic [1:0] col;
        col = st[1:0];
        case (st[STEP_W-1:STEP_W-2])
            2'd0: case (col)
                      2'd0: return 5'd7;
                      2'd1: return 5'd12;
                      2'd2: return 5'd17;
                      default: return 5'd22;
                  endcase
            2'd1: case (col)
                      2'd0: return 5'd5;
                      2'd1: return 5'd9;
                      2'd2: return 5'd14;
                      default: return 5'd20;
                  endcase
            2'd2: case (col)
                      2'd0: return 5'd4;
                      2'd1: return 5'd11;
                      2'd2: return 5'd16;
                      default: return 5'd23;
                  endcase
            default: case (col)
                      2'd0: return 5'd6;
                      2'd1: return 5'd10;
                      2'd2: return 5'd15;
                      default: return 5'd21;
                  endcase
        endcase
    endfunction

endpackage

// File: rtl/md5_const_rom.sv
// Module md5_const_rom
// Combinational lookup of the additive constant and rotation amount for a step.
// Assumes the step index is valid (0..63); pure logic, no state.
module md5_const_rom
    import md5_pkg::*;
(
    input  step_t            step_i,
    output word_t            k_o,
    output logic [ROT_W-1:0] rot_o
);

    // Additive constant selected by step number.
    always_comb begin
        case (step_i)
            6'd0:  k_o = 32'hd76aa478;
            6'd1:  k_o = 32'he8c7b756;
            6'd2:  k_o = 32'h242070db;
            6'd3:  k_o = 32'hc1bdceee;
            6'd4:  k_o = 32'hf57c0faf;
            6'd5:  k_o = 32'h4787c62a;
            6'd6:  k_o = 32'ha8304613;
            6'd7:  k_o = 32'hfd469501;
            6'd8:  k_o = 32'h698098d8;
            6'd9:  k_o = 32'h8b44f7af;
            6'd10: k_o = 32'hffff5bb1;
            6'd11: k_o = 32'h895cd7be;
            6'd12: k_o = 32'h6b901122;
            6'd13: k_o = 32'hfd987193;
            6'd14: k_o = 32'ha679438e;
            6'd15: k_o = 32'h49b40821;
            6'd16: k_o = 32'hf61e2562;
            6'd17: k_o = 32'hc040b340;
            6'd18: k_o = 32'h265e5a51;
            6'd19: k_o = 32'he9b6c7aa;
            6'd20: k_o = 32'hd62f105d;
            6'd21: k_o = 32'h02441453;
            6'd22: k_o = 32'hd8a1e681;
            6'd23: k_o = 32'he7d3fbc8;
            6'd24: k_o = 32'h21e1cde6;
            6'd25: k_o = 32'hc33707d6;
            6'd26: k_o = 32'hf4d50d87;
            6'd27: k_o = 32'h455a14ed;
            6'd28: k_o = 32'ha9e3e905;
            6'd29: k_o = 32'hfcefa3f8;
            6'd30: k_o = 32'h676f02d9;
            6'd31: k_o = 32'h8d2a4c8a;
            6'd32: k_o = 32'hfffa3942;
            6'd33: k_o = 32'h8771f681;
            6'd34: k_o = 32'h6d9d6122;
            6'd35: k_o = 32'hfde5380c;
            6'd36: k_o = 32'ha4beea44;
            6'd37: k_o = 32'h4bdecfa9;
            6'd38: k_o = 32'hf6bb4b60;
            6'd39: k_o = 32'hbebfbc70;
            6'd40: k_o = 32'h289b7ec6;
            6'd41: k_o = 32'heaa127fa;
            6'd42: k_o = 32'hd4ef3085;
            6'd43: k_o = 32'h04881d05;
            6'd44: k_o = 32'hd9d4d039;
            6'd45: k_o = 32'he6db99e5;
            6'd46: k_o = 32'h1fa27cf8;
            6'd47: k_o = 32'hc4ac5665;
            6'd48: k_o = 32'hf4292244;
            6'd49: k_o = 32'h432aff97;
            6'd50: k_o = 32'hab9423a7;
            6'd51: k_o = 32'hfc93a039;
            6'd52: k_o = 32'h655b59c3;
            6'd53: k_o = 32'h8f0ccc92;
            6'd54: k_o = 32'hffeff47d;
            6'd55: k_o = 32'h85845dd1;
            6'd56: k_o = 32'h6fa87e4f;
            6'd57: k_o = 32'hfe2ce6e0;
            6'd58: k_o = 32'ha3014314;
            6'd59: k_o = 32'h4e0811a1;
            6'd60: k_o = 32'hf7537e82;
            6'd61: k_o = 32'hbd3af235;
            6'd62: k_o = 32'h2ad7d2bb;
            default: k_o = 32'heb86d391;
        endcase
    end

    // Rotation amount comes from the shared schedule function.
    always_comb rot_o = rot_amount(step_i);

endmodule

// File: rtl/md5_step_unit.sv
// Module md5_step_unit
// Combinational datapath of one MD5 step: picks the round's boolean function,
// sums it with the a-word, message word and constant, rotates, and adds b.
// Assumes the caller performs the register role rotation (a,b,c,d)->(d,new,b,c).
module md5_step_unit
    import md5_pkg::*;
(
    input  logic [1:0]       round_i,
    input  word_t            a_i,
    input  word_t            b_i,
    input  word_t            c_i,
    input  word_t            d_i,
    input  word_t            msg_i,
    input  word_t            k_i,
    input  logic [ROT_W-1:0] rot_i,
    output word_t            new_b_o
);

    word_t mix;
    word_t sum;

    // Round-dependent nonlinear mixing of b, c and d.
    always_comb begin
        case (round_i)
            2'd0:    mix = (b_i & c_i) | (~b_i & d_i);
            2'd1:    mix = (b_i & d_i) | (c_i & ~d_i);
            2'd2:    mix = b_i ^ c_i ^ d_i;
            default: mix = c_i ^ (b_i | ~d_i);
        endcase
    end

    // Modular sum, rotation and final add of b.
    always_comb begin
        sum     = a_i + mix + msg_i + k_i;
        new_b_o = b_i + rotl32(sum, rot_i);
    end

endmodule

// File: rtl/md5_ctrl.sv
// Module md5_ctrl
// Sequencer for the iterative engine: accepts a start when idle, counts the 64
// steps, and raises a one-cycle done after the last one. Starts seen while
// running are ignored. Synchronous active-low reset.
module md5_ctrl
    import md5_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start_i,
    output logic  load_o,
    output logic  adv_o,
    output logic  last_o,
    output step_t step_o,
    output logic  busy_o,
    output logic  done_o
);

    typedef enum logic {S_IDLE, S_RUN} ctrl_state_e;

    ctrl_state_e state_q;
    step_t       step_q;

    // Strobes for the datapath derived from the current state.
    always_comb begin
        load_o = (state_q == S_IDLE) && start_i;
        adv_o  = (state_q == S_RUN);
        last_o = adv_o && (step_q == step_t'(NUM_STEPS - 1));
        step_o = step_q;
        busy_o = (state_q == S_RUN);
    end

    // State, step counter and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            step_q  <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (load_o) begin
                state_q <= S_RUN;
                step_q  <= '0;
            end else if (last_o) begin
                state_q <= S_IDLE;
                step_q  <= '0;
                done_o  <= 1'b1;
            end else if (adv_o) begin
                step_q <= step_q + 1'b1;
            end
        end
    end

    // R2
    done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R2
    busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    // R2
    done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(busy_o));

    // R8
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && step_q != step_t'(NUM_STEPS - 1)) |=> busy_o);

endmodule

// File: rtl/md5_core.sv
// Module md5_core
// Iterative MD5 compression of one padded 512-bit block, one step per clock.
// Holds the block, the input chaining value and the four working words;
// after step 63 adds the input chaining value back and publishes the result
// as raw words and as a byte-ordered digest. Assumes a synchronous
// active-low reset and that padding is done outside.
module md5_core
    import md5_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 init_i,
    input  logic [BLOCK_W-1:0]   block_i,
    input  logic [STATE_W-1:0]   state_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic [STATE_W-1:0]   state_o,
    output logic [STATE_W-1:0]   digest_o
);

    logic             load, adv, last;
    step_t            step;
    word_t            k_val;
    logic [ROT_W-1:0] rot;
    word_t            new_b;
    word_t            msg_word;

    logic [BLOCK_W-1:0] blk_q;
    word_t              wa_q, wb_q, wc_q, wd_q;
    word_t              ha_q, hb_q, hc_q, hd_q;
    word_t              sa_q, sb_q, sc_q, sd_q;
    word_t              src_a, src_b, src_c, src_d;
    word_t              words [NUM_WORDS];

    md5_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .load_o  (load),
        .adv_o   (adv),
        .last_o  (last),
        .step_o  (step),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    md5_const_rom u_rom (
        .step_i (step),
        .k_o    (k_val),
        .rot_o  (rot)
    );

    // Split the held block into its sixteen message words.
    for (genvar j = 0; j < NUM_WORDS; j++) begin : g_words
        assign words[j] = blk_q[WORD_W*j +: WORD_W];
    end

    // Message word chosen by the step schedule.
    always_comb msg_word = words[msg_index(step)];

    md5_step_unit u_step (
        .round_i (step[STEP_W-1:STEP_W-2]),
        .a_i     (wa_q),
        .b_i     (wb_q),
        .c_i     (wc_q),
        .d_i     (wd_q),
        .msg_i   (msg_word),
        .k_i     (k_val),
        .rot_i   (rot),
        .new_b_o (new_b)
    );

    // Input chaining value: fixed vector or caller-supplied words.
    always_comb begin
        if (init_i) begin
            src_a = IV_A; src_b = IV_B; src_c = IV_C; src_d = IV_D;
        end else begin
            src_a = state_i[127:96]; src_b = state_i[95:64];
            src_c = state_i[63:32];  src_d = state_i[31:0];
        end
    end

    // Capture inputs at start and rotate working words on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q <= '0;
            {ha_q, hb_q, hc_q, hd_q} <= '0;
            {wa_q, wb_q, wc_q, wd_q} <= '0;
        end else if (load) begin
            blk_q <= block_i;
            {ha_q, hb_q, hc_q, hd_q} <= {src_a, src_b, src_c, src_d};
            {wa_q, wb_q, wc_q, wd_q} <= {src_a, src_b, src_c, src_d};
        end else if (adv) begin
            wa_q <= wd_q;
            wb_q <= new_b;
            wc_q <= wb_q;
            wd_q <= wc_q;
        end
    end

    // Feed-forward add of the input chaining value on the final step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {sa_q, sb_q, sc_q, sd_q} <= '0;
        end else if (last) begin
            sa_q <= ha_q + wd_q;
            sb_q <= hb_q + new_b;
            sc_q <= hc_q + wb_q;
            sd_q <= hd_q + wc_q;
        end
    end

    // Raw words for chaining and byte-ordered digest for comparison.
    always_comb begin
        state_o  = {sa_q, sb_q, sc_q, sd_q};
        digest_o = {bswap32(sa_q), bswap32(sb_q), bswap32(sc_q), bswap32(sd_q)};
    end

    // R3
    iv_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy_o) && $past(init_i)) |->
        (wa_q == IV_A && wb_q == IV_B && wc_q == IV_C && wd_q == IV_D));

    // R8
    blk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(blk_q));

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !done_o) |-> $stable(state_o));

endmodule

// File: tb/md5_core_tb_top.sv
// Bench md5_core_tb_top
// Behavioural cycle model of busy/done compared every clock, plus a
// behavioural MD5 step function predicting each result.
module md5_core_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         init_i = 1'b0;
    logic [511:0] block_i = '0;
    logic [127:0] state_i = '0;
    logic         busy_o, done_o;
    logic [127:0] state_o, digest_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit model_on = 0;

    // model state
    bit m_busy = 0;
    bit m_done = 0;
    int m_cnt  = 0;

    always #5 clk = ~clk;

    md5_core dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .init_i   (init_i),
        .block_i  (block_i),
        .state_i  (state_i),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .state_o  (state_o),
        .digest_o (digest_o)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] sine_const(input int i);
        real r;
        r = $sin(real'(i + 1));
        if (r < 0.0) r = -r;
        return 32'(longint'($floor(r * 4294967296.0)));
    endfunction

    function automatic logic [127:0] md5_ref(input logic [127:0] st, input logic [511:0] blk);
        int rt [4][4] = '{'{7, 12, 17, 22}, '{5, 9, 14, 20}, '{4, 11, 16, 23}, '{6, 10, 15, 21}};
        logic [31:0] a, b, c, d, f, t;
        int g, s;
        a = st[127:96]; b = st[95:64]; c = st[63:32]; d = st[31:0];
        for (int i = 0; i < 64; i++) begin
            case (i / 16)
                0: begin f = (b & c) | (~b & d); g = i; end
                1: begin f = (b & d) | (c & ~d); g = (5 * i + 1) % 16; end
                2: begin f = b ^ c ^ d; g = (3 * i + 5) % 16; end
                default: begin f = c ^ (b | ~d); g = (7 * i) % 16; end
            endcase
            s = rt[i / 16][i % 4];
            t = a + f + blk[32*g +: 32] + sine_const(i);
            t = (t << s) | (t >> (32 - s));
            a = d; d = c; c = b; b = b + t;
        end
        return {st[127:96] + a, st[95:64] + b, st[63:32] + c, st[31:0] + d};
    endfunction

    function automatic logic [127:0] to_bytes(input logic [127:0] w);
        logic [127:0] r;
        for (int k = 0; k < 16; k++)
            r[127 - 8*k -: 8] = w[(127 - 32*(k/4)) - 31 + 8*(k%4) +: 8];
        return r;
    endfunction

    // Cycle model of the handshake, driven by the requirements (R2, R8).
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_cnt = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_cnt++;
                if (m_cnt == 64) begin m_busy = 0; m_done = 1; end
            end else if (start_i) begin
                m_busy = 1; m_cnt = 0;
            end
        end
    end

    // Compare handshake against the model every clock (R2).
    always @(negedge clk) begin
        if (model_on) begin
            check("R2 busy", {127'd0, busy_o}, {127'd0, m_busy});
            check("R2 done", {127'd0, done_o}, {127'd0, m_done});
        end
    end

    task automatic wait_done();
        int guard = 0;
        while (!done_o && guard < 300) begin
            @(negedge clk);
            guard++;
        end
        if (!done_o) check("R2 done never seen", 128'd0, 128'd1);
    endtask

    task automatic run_block(input logic [511:0] blk, input logic [127:0] st,
                             input bit ini, output logic [127:0] exp);
        logic [127:0] src;
        src = ini ? {32'h67452301, 32'hefcdab89, 32'h98badcfe, 32'h10325476} : st;
        exp = md5_ref(src, blk);
        block_i = blk; state_i = st; init_i = ini; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done();
    endtask

    logic [511:0] empty_blk, abc_blk, blk2;
    logic [127:0] exp, exp1, st1;

    initial begin
        empty_blk = '0; empty_blk[7] = 1'b1;
        abc_blk = '0; abc_blk[31:0] = 32'h80636261; abc_blk[14*32 +: 32] = 32'd24;

        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy", {127'd0, busy_o}, 128'd0);
        check("R1 done", {127'd0, done_o}, 128'd0);
        check("R1 state", state_o, 128'd0);
        check("R1 digest", digest_o, 128'd0);
        rst_n = 1'b1;
        model_on = 1;
        @(negedge clk);

        // R3 R5 R7: empty message with a wrong state_i present
        run_block(empty_blk, 128'hdeadbeef_01234567_89abcdef_55aa55aa, 1'b1, exp);
        check("R5 empty digest", digest_o, 128'hd41d8cd98f00b204e9800998ecf8427e);
        check("R3 iv state", state_o, exp);
        check("R7 byte order", digest_o, to_bytes(state_o));
        @(negedge clk);

        // R5 "abc"
        run_block(abc_blk, '0, 1'b1, exp);
        check("R5 abc digest", digest_o, 128'h900150983cd24fb0d6963f7d28e17f72);

        // R4 R6: two-block chain
        blk2 = {16{$urandom()}};
        for (int j = 0; j < 16; j++) blk2[32*j +: 32] = $urandom();
        run_block(blk2, '0, 1'b1, exp1);
        check("R6 chain first", state_o, exp1);
        st1 = state_o;
        @(negedge clk);
        for (int j = 0; j < 16; j++) blk2[32*j +: 32] = $urandom();
        run_block(blk2, st1, 1'b0, exp);
        check("R4 chain second", state_o, exp);
        check("R7 chain digest", digest_o, to_bytes(exp));

        // R4 R6: arbitrary chaining values
        for (int n = 0; n < 3; n++) begin
            logic [127:0] st;
            st = {$urandom(), $urandom(), $urandom(), $urandom()};
            for (int j = 0; j < 16; j++) blk2[32*j +: 32] = $urandom();
            run_block(blk2, st, 1'b0, exp);
            check("R6 feed-forward", state_o, exp);
        end

        // R2: new start in the done cycle is accepted
        for (int j = 0; j < 16; j++) blk2[32*j +: 32] = $urandom();
        exp = md5_ref(state_o, blk2);
        block_i = blk2; state_i = state_o; init_i = 1'b0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done();
        check("R2 back-to-back result", state_o, exp);

        // R8: disturbances while busy
        @(negedge clk);
        for (int j = 0; j < 16; j++) blk2[32*j +: 32] = $urandom();
        exp = md5_ref({32'h67452301, 32'hefcdab89, 32'h98badcfe, 32'h10325476}, blk2);
        block_i = blk2; init_i = 1'b1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (10) @(negedge clk);
        block_i = ~blk2; state_i = 128'h1; init_i = 1'b0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (20) @(negedge clk);
        block_i = '0; init_i = 1'b1;
        wait_done();
        check("R8 result unaffected", state_o, exp);

        // R9: result holds with changing inputs and no start
        @(negedge clk);
        for (int n = 0; n < 5; n++) begin
            block_i = {16{$urandom()}}; state_i = {4{$urandom()}}; init_i = n[0];
            @(negedge clk);
            check("R9 state hold", state_o, exp);
            check("R9 digest hold", digest_o, to_bytes(exp));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule